// File: doc/BRIEF.md
# Flagged 16-bit Add/Shift Arithmetic Unit

This block is a purely combinational arithmetic unit. It takes two 16-bit operands and a 3-bit command. From these it produces a 16-bit result and three status flags: zero, overflow and carry.

- **Additions.** Two commands add the operands. One treats them as unsigned numbers and the other as two's-complement numbers. Both give the same 16-bit sum, but each defines its overflow flag in its own way.
- **Shifts.** Two commands shift the first operand left or right. The shift amount comes from the low four bits of the second operand. Vacated positions fill with zeros. The carry flag captures the last bit that left the word.
- **Spare commands.** The four unused command codes give a silent zero result.

The unit has no clock and no state. Its outputs follow its inputs after logic delay only, so it can sit directly in a datapath stage between a register file and a write-back multiplexer.

Top module: `flag_alu`

## Requirements
- R1: With cmd = 3'b000 (unsigned add), result equals (op_a + op_b) mod 2^16 and flag_carry equals bit 16 of the 17-bit sum.
- R2: With cmd = 3'b000, flag_ovf equals flag_carry.
- R3: With cmd = 3'b001 (signed add), result and flag_carry are as in R1. flag_ovf is 1 exactly when op_a[15] equals op_b[15] and result[15] differs from them.
- R4: With cmd = 3'b010 (logical right shift), result is op_a shifted right by op_b[3:0] with zeros entering at bit 15. Bits op_b[15:4] have no effect on any output.
- R5: With cmd = 3'b011 (logical left shift), result is op_a shifted left by op_b[3:0] with zeros entering at bit 0.
- R6: For both shifts, flag_carry is the last bit shifted out, and it is 0 when op_b[3:0] is 0. For a right shift by n > 0 this is op_a[n-1]. For a left shift by n > 0 it is op_a[16-n].
- R7: For both shifts, flag_ovf is 0.
- R8: For every command, flag_zero is 1 exactly when all 16 result bits are 0.
- R9: Commands 3'b100 to 3'b111 give result 0, flag_carry 0, flag_ovf 0 and flag_zero 1, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand; the value shifted by the shift commands |
| op_b | input | 16 | Second operand; its low 4 bits are the shift amount |
| cmd | input | 3 | Operation select (encodings in R1 to R9) |
| result | output | 16 | Operation result |
| flag_zero | output | 1 | High when result is all zeros |
| flag_ovf | output | 1 | Overflow as defined per command |
| flag_carry | output | 1 | Carry out of bit 15, or last bit shifted out |

## Verification
The zero flag can rise in the same evaluation as the carry and overflow flags. Examples are an unsigned wrap such as 0xFFFF + 0x0001, a signed sum of two minimum negatives, and a left shift that pushes the only set bit out of the word. The bench applies such operand pairs and compares all four outputs at once against values derived from the requirements, so a design that lets one flag mask another is caught. A second class of collision is a shift with a zero amount carrying non-zero upper bits in op_b. Here the bench expects an unchanged operand and a cleared carry.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned CMD_W   = 3;
    localparam int unsigned SHAMT_W = $clog2(DATA_W);

    typedef enum logic [CMD_W-1:0] {
        CMD_ADD_U = 3'b000,
        CMD_ADD_S = 3'b001,
        CMD_SHR   = 3'b010,
        CMD_SHL   = 3'b011
    } alu_cmd_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              ovf;
    } alu_out_t;

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    output logic [W-1:0] add_sum,
    output logic         add_cout,
    output logic         add_sovf
);

    logic [W:0] wide_d;

    always_comb begin
        wide_d   = {1'b0, add_a} + {1'b0, add_b};
        add_sum  = wide_d[W-1:0];
        add_cout = wide_d[W];
        // two's-complement overflow: equal input signs, different result sign
        add_sovf = (add_a[W-1] == add_b[W-1]) && (wide_d[W-1] != add_a[W-1]);
    end

endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter #(
    parameter int unsigned W  = 16,
    parameter int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]  sh_in,
    input  logic [SW-1:0] sh_amt,
    input  logic          sh_left,
    output logic [W-1:0]  sh_out,
    output logic          sh_last
);

    logic [W-1:0]  stage_d [SW+1];
    logic [SW-1:0] idx_l_d;
    logic [SW-1:0] idx_r_d;

    assign stage_d[0] = sh_in;

    // log2(W) barrel stages, stage k moves by 2^k positions
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        always_comb begin
            if (!sh_amt[k]) begin
                stage_d[k+1] = stage_d[k];
            end else if (sh_left) begin
                stage_d[k+1] = stage_d[k] << STEP;
            end else begin
                stage_d[k+1] = stage_d[k] >> STEP;
            end
        end
    end

    assign sh_out = stage_d[SW];

    // last departing bit picked straight from the input word
    always_comb begin
        idx_l_d = SW'(W - int'(sh_amt));
        idx_r_d = sh_amt - SW'(1);
        if (sh_amt == '0) begin
            sh_last = 1'b0;
        end else if (sh_left) begin
            sh_last = sh_in[idx_l_d];
        end else begin
            sh_last = sh_in[idx_r_d];
        end
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
(
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [CMD_W-1:0]  cmd,
    output logic [DATA_W-1:0] result,
    output logic              flag_zero,
    output logic              flag_ovf,
    output logic              flag_carry
);

    logic [DATA_W-1:0] sum_d;
    logic              cout_d;
    logic              sovf_d;
    logic [DATA_W-1:0] shv_d;
    logic              shlast_d;
    alu_out_t          out_d;

    flag_alu_adder #(.W(DATA_W)) u_adder (
        .add_a   (op_a),
        .add_b   (op_b),
        .add_sum (sum_d),
        .add_cout(cout_d),
        .add_sovf(sovf_d)
    );

    flag_alu_shifter #(.W(DATA_W), .SW(SHAMT_W)) u_shifter (
        .sh_in  (op_a),
        .sh_amt (op_b[SHAMT_W-1:0]),
        .sh_left(cmd[0]),
        .sh_out (shv_d),
        .sh_last(shlast_d)
    );

    always_comb begin
        out_d = '0;
        case (alu_cmd_e'(cmd))
            CMD_ADD_U: out_d = '{value: sum_d, carry: cout_d, ovf: cout_d};
            CMD_ADD_S: out_d = '{value: sum_d, carry: cout_d, ovf: sovf_d};
            CMD_SHR,
            CMD_SHL:   out_d = '{value: shv_d, carry: shlast_d, ovf: 1'b0};
            default:   out_d = '0;
        endcase
    end

    assign result     = out_d.value;
    assign flag_carry = out_d.carry;
    assign flag_ovf   = out_d.ovf;
    assign flag_zero  = ~|out_d.value;

    // checks relating the outputs back to the operands and command
    always_comb begin
        if (cmd == CMD_ADD_U) begin
            a_r2_uadd_ovf_tracks_carry: assert (flag_ovf == flag_carry);
        end
        if (cmd == CMD_ADD_S && flag_ovf) begin
            a_r3_sovf_sign_rule: assert ((op_a[DATA_W-1] == op_b[DATA_W-1]) &&
                                         (result[DATA_W-1] != op_a[DATA_W-1]));
        end
        if (cmd == CMD_SHR || cmd == CMD_SHL) begin
            a_r7_shift_no_ovf: assert (!flag_ovf);
            if (op_b[SHAMT_W-1:0] == '0) begin
                a_r6_zero_shift_passthru: assert (!flag_carry && result == op_a);
            end
        end
        if (cmd[CMD_W-1]) begin
            a_r9_spare_quiet: assert (result == '0 && flag_zero && !flag_carry && !flag_ovf);
        end
    end

endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

    logic        clk = 1'b0;
    logic [15:0] op_a, op_b;
    logic [2:0]  cmd;
    logic [15:0] result;
    logic        flag_zero, flag_ovf, flag_carry;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flag_alu dut (
        .op_a(op_a), .op_b(op_b), .cmd(cmd),
        .result(result), .flag_zero(flag_zero),
        .flag_ovf(flag_ovf), .flag_carry(flag_carry)
    );

    // a, b, cmd, result, z, v, c
    localparam int NV = 15;
    localparam logic [53:0] VECS [NV] = '{
        {16'h0001, 16'h0002, 3'd0, 16'h0003, 1'b0, 1'b0, 1'b0}, // R1
        {16'hFFFF, 16'h0001, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1}, // R1 R2 R8
        {16'h8000, 16'h8000, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1}, // R2
        {16'h7FFF, 16'h0001, 3'd1, 16'h8000, 1'b0, 1'b1, 1'b0}, // R3
        {16'h8000, 16'hFFFF, 3'd1, 16'h7FFF, 1'b0, 1'b1, 1'b1}, // R3
        {16'hFFFF, 16'h0001, 3'd1, 16'h0000, 1'b1, 1'b0, 1'b1}, // R3
        {16'h8001, 16'h0001, 3'd2, 16'h4000, 1'b0, 1'b0, 1'b1}, // R4 R6
        {16'h8001, 16'h0010, 3'd2, 16'h8001, 1'b0, 1'b0, 1'b0}, // R4 R6
        {16'h8000, 16'h000F, 3'd2, 16'h0001, 1'b0, 1'b0, 1'b0}, // R4
        {16'h0003, 16'h0002, 3'd2, 16'h0000, 1'b1, 1'b0, 1'b1}, // R6 R8
        {16'h8001, 16'h0001, 3'd3, 16'h0002, 1'b0, 1'b0, 1'b1}, // R5 R6
        {16'h0001, 16'h000F, 3'd3, 16'h8000, 1'b0, 1'b0, 1'b0}, // R5
        {16'h4000, 16'h0002, 3'd3, 16'h0000, 1'b1, 1'b0, 1'b1}, // R5 R6 R8
        {16'h1234, 16'h5678, 3'd4, 16'h0000, 1'b1, 1'b0, 1'b0}, // R9
        {16'hFFFF, 16'hFFFF, 3'd7, 16'h0000, 1'b1, 1'b0, 1'b0}  // R9
    };

    task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cmd=%0d got res=%h z%b v%b c%b exp res=%h z%b v%b c%b",
                     req, op_a, op_b, cmd, got[18:3], got[2], got[1], got[0],
                     exp[18:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // behavioural model written from the requirements
    function automatic logic [18:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [2:0] c);
        logic [16:0] s;
        logic [15:0] r;
        logic cy, ov;
        s = 17'(a) + 17'(b);
        r = '0; cy = 1'b0; ov = 1'b0;
        case (c)
            3'd0: begin r = s[15:0]; cy = s[16]; ov = s[16]; end
            3'd1: begin r = s[15:0]; cy = s[16];
                        ov = (a[15] == b[15]) && (s[15] != a[15]); end
            3'd2, 3'd3: begin
                r = a;
                for (int i = 0; i < int'(b[3:0]); i++) begin
                    if (c == 3'd2) begin cy = r[0];  r = r >> 1; end
                    else           begin cy = r[15]; r = r << 1; end
                end
            end
            default: ;
        endcase
        return {r, (r == 16'h0), ov, cy};
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1/R2/R8";
            3'd1: return "R3/R8";
            3'd2: return "R4/R6/R7";
            3'd3: return "R5/R6/R7";
            default: return "R9";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        op_a = '0; op_b = '0; cmd = '0;
        @(negedge clk);
        // table walk
        for (int i = 0; i < NV; i++) begin
            op_a = VECS[i][53:38];
            op_b = VECS[i][37:22];
            cmd  = VECS[i][21:19];
            @(negedge clk);
            check(tag_of(cmd), {result, flag_zero, flag_ovf, flag_carry}, VECS[i][18:0]);
        end
        // R4: upper bits of the shift operand ignored, all amounts
        for (int n = 0; n < 16; n++) begin
            op_a = 16'hB5C3; cmd = 3'd2;
            op_b = 16'(n);
            @(negedge clk);
            begin
                logic [18:0] ref_lo;
                ref_lo = {result, flag_zero, flag_ovf, flag_carry};
                op_b = 16'hFFF0 | 16'(n);
                @(negedge clk);
                check("R4", {result, flag_zero, flag_ovf, flag_carry}, ref_lo);
            end
            check("R6", {result, flag_zero, flag_ovf, flag_carry}, model(op_a, op_b, 3'd2));
            cmd = 3'd3;
            @(negedge clk);
            check("R5", {result, flag_zero, flag_ovf, flag_carry}, model(op_a, op_b, 3'd3));
        end
        // pseudo-random sweep over every command code
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op_a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op_b = lfsr ^ 16'(i * 16'h3B7);
            cmd  = 3'(i);
            @(negedge clk);
            check(tag_of(cmd), {result, flag_zero, flag_ovf, flag_carry}, model(op_a, op_b, cmd));
        end
        // R7: shift never reports overflow, even for max operands
        op_a = 16'hFFFF; op_b = 16'hFFFF; cmd = 3'd3;
        @(negedge clk);
        check("R7", {15'd0, 1'b0, 1'b0, flag_ovf, 1'b0}, 19'd0);
        finish_run();
    end

endmodule